// File: doc/BRIEF.md
# Interrupt Line Router with Edge Pending Latch

This block samples a flat vector of interrupt input lines on every clock and sorts each line into one of two classes. The low part of the vector carries shared interrupts, which belong to a single distributor bank. The high part is cut into slots of 32 lines, one slot per processor, and carries that processor's private interrupts. For every legal line the block keeps the last sampled level, a trigger-mode bit that software sets, and a pending bit. A rising edge on a line configured as edge-triggered sets that line's pending bit.

Each change of level produces one update strobe. A shared line's strobe names its interrupt ID. A private line's strobe names the processor whose bank changed. When several lines change in the same cycle, all state bits update together. The strobes are then issued one per cycle, lowest line index first.

The first 16 IDs of each processor slot are reserved for software-generated interrupts. Slots beyond the processor count are unused. A line in either region is never stored. When such a line is driven it raises a mapping error instead. A word-addressed register port writes the trigger-mode bits, clears pending bits by writing ones, and reads back both.

Top module: `irq_route_latch`

## Requirements
- R1: Shared line k, with k below NUM_IRQ-32, produces one strobe with upd_private_o=0 and upd_num_o=k+32 in the cycle after its level changes.
- R2: Private line NUM_IRQ-32+32*c+o, with o at least 16 and c below NUM_CPU, produces a strobe with upd_private_o=1 and upd_num_o=c.
- R3: A line sampled at the same level it already holds produces no strobe and changes no state.
- R4: The pending bit is set only by a 0-to-1 change on a line whose trigger bit is 1 (edge). A falling change does not set it. A line whose trigger bit is 0 (level) never sets it.
- R5: A private line with offset o below 16 is never stored, never pends and never strobes. map_err_o is 1 in each cycle after a cycle in which such a line was sampled high.
- R6: A line in slot c with c at least NUM_CPU behaves as in R5.
- R7: When several lines change in one cycle, their strobes appear on consecutive cycles in ascending line index, the first one in the cycle after the change.
- R8: Register word a holds line bits 32*a to 32*a+31 (word 0 = shared IDs 32..63, word NUM_IRQ/32-1+c = processor c, bit = ID). A write with cfg_trig_we_i stores the trigger bits. Bits of illegal lines read as 0. rd_trig_o and rd_pend_o show word cfg_addr_i one cycle after it is presented.
- R9: A write with cfg_clr_we_i clears the pending bits that are set in cfg_wdata_i. If the same bit is set by an edge in that cycle, the bit ends up set.
- R10: After a synchronous active-high reset, all level, trigger and pending bits are 0, and no strobe or error is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | NUM_IRQ-32+32*NUM_SLOTS | Flat interrupt input vector |
| cfg_addr_i | input | AW | Register word address |
| cfg_wdata_i | input | 32 | Write data for the trigger write or the pending clear |
| cfg_trig_we_i | input | 1 | Write the trigger-mode word |
| cfg_clr_we_i | input | 1 | Clear pending bits where the data bit is 1 |
| rd_trig_o | output | 32 | Trigger-mode word at the address (registered) |
| rd_pend_o | output | 32 | Pending word at the address (registered) |
| upd_valid_o | output | 1 | Update strobe |
| upd_private_o | output | 1 | 1 when the strobe names a processor bank |
| upd_num_o | output | $clog2(NUM_IRQ) | Interrupt ID, or processor number |
| map_err_o | output | 1 | An illegal line was sampled high |

## Verification
The bench drives lines in the reserved software-generated range and in an unused processor slot. A design that stored those lines would strobe or pend for them. It also repeats a line at the level it already holds, which a design without the level compare would strobe. Three lines rise together, so an encoder that drops strobes or issues them out of index order gives a wrong sequence. A clear and an edge are made to hit the same pending bit in one cycle: a design where the clear wins loses that interrupt. Writes of all ones to the trigger words catch a design that lets reserved bits be set.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int LINES_PER_CPU = 32;
  localparam int FIRST_PRIVATE_ID = 16;
  localparam int REG_BITS = 32;
endpackage

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SPI   = 32,
  parameter int NUM_CPU   = 2,
  parameter int W         = 128,
  parameter int WORDS     = 4,
  parameter int AW        = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        lines_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [REG_BITS-1:0] wdata_i,
  input  logic                trig_we_i,
  input  logic                clr_we_i,
  output logic [REG_BITS-1:0] rd_trig_o,
  output logic [REG_BITS-1:0] rd_pend_o,
  output logic [W-1:0]        chg_o,
  output logic                err_o
);
  logic [W-1:0] legal, lvl_q, trig_q, pend_q;
  logic [W-1:0] diff, set_vec, clr_vec;

  for (genvar i = 0; i < W; i++) begin : g_legal
    if (i < NUM_SPI) begin : g_shared
      assign legal[i] = 1'b1;
    end else begin : g_private
      assign legal[i] = (((i - NUM_SPI) % LINES_PER_CPU) >= FIRST_PRIVATE_ID) &&
                        (((i - NUM_SPI) / LINES_PER_CPU) < NUM_CPU);
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_clr
    assign clr_vec[w*REG_BITS +: REG_BITS] =
      (clr_we_i && addr_i == AW'(w)) ? wdata_i : '0;
  end

  assign diff    = (lines_i ^ lvl_q) & legal;
  assign set_vec = diff & lines_i & trig_q;
  assign chg_o   = diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= '0;
      trig_q    <= '0;
      pend_q    <= '0;
      rd_trig_o <= '0;
      rd_pend_o <= '0;
      err_o     <= 1'b0;
    end else begin
      lvl_q  <= lvl_q ^ diff;
      pend_q <= ((pend_q & ~clr_vec) | set_vec) & legal;
      err_o  <= |(lines_i & ~legal);
      rd_trig_o <= '0;
      rd_pend_o <= '0;
      for (int w = 0; w < WORDS; w++) begin
        if (trig_we_i && addr_i == AW'(w))
          trig_q[w*REG_BITS +: REG_BITS] <= wdata_i & legal[w*REG_BITS +: REG_BITS];
        if (addr_i == AW'(w)) begin
          rd_trig_o <= trig_q[w*REG_BITS +: REG_BITS];
          rd_pend_o <= pend_q[w*REG_BITS +: REG_BITS];
        end
      end
    end
  end

  // R4: a pending bit only turns on from an edge set in the previous cycle
  assert_pend_from_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0);

  // R9: a set in the same cycle as a clear survives
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_q & $past(set_vec)) == $past(set_vec));

  // R5 / R6: illegal lines never hold trigger or pending state
  assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ((pend_q | trig_q | lvl_q) & ~legal) == '0);
endmodule

// File: rtl/irq_upd_queue.sv
module irq_upd_queue
  import irq_route_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int W       = 128,
  parameter int IDW     = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   chg_i,
  output logic           upd_valid_o,
  output logic           upd_private_o,
  output logic [IDW-1:0] upd_num_o
);
  localparam int PW = $clog2(W);

  logic [W-1:0]  wait_q, pool;
  logic [PW-1:0] pick;
  logic          any;

  always_comb begin
    pool = wait_q | chg_i;
    any  = |pool;
    pick = '0;
    for (int i = W - 1; i >= 0; i--)
      if (pool[i]) pick = PW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q        <= '0;
      upd_valid_o   <= 1'b0;
      upd_private_o <= 1'b0;
      upd_num_o     <= '0;
    end else begin
      upd_valid_o <= any;
      wait_q      <= any ? (pool & ~(W'(1) << pick)) : pool;
      if (int'(pick) < NUM_SPI) begin
        upd_private_o <= 1'b0;
        upd_num_o     <= IDW'(int'(pick) + LINES_PER_CPU);
      end else begin
        upd_private_o <= 1'b1;
        upd_num_o     <= IDW'((int'(pick) - NUM_SPI) / LINES_PER_CPU);
      end
    end
  end

  // R7: any change yields a strobe in the next cycle
  assert_strobe_after_change_R7: assert property (@(posedge clk) disable iff (rst)
    (chg_i != '0) |=> upd_valid_o);

  // R3: nothing waiting and nothing changed means no strobe
  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (wait_q == '0 && chg_i == '0) |=> !upd_valid_o);
endmodule

// File: rtl/irq_route_latch.sv
module irq_route_latch
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CPU   = 2,
  parameter int NUM_SLOTS = 3
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [NUM_IRQ-32+32*NUM_SLOTS-1:0]            irq_lines_i,
  input  logic [$clog2((NUM_IRQ-32)/32+NUM_SLOTS)-1:0]  cfg_addr_i,
  input  logic [31:0]                                   cfg_wdata_i,
  input  logic                                          cfg_trig_we_i,
  input  logic                                          cfg_clr_we_i,
  output logic [31:0]                                   rd_trig_o,
  output logic [31:0]                                   rd_pend_o,
  output logic                                          upd_valid_o,
  output logic                                          upd_private_o,
  output logic [$clog2(NUM_IRQ)-1:0]                    upd_num_o,
  output logic                                          map_err_o
);
  localparam int NUM_SPI = NUM_IRQ - LINES_PER_CPU;
  localparam int W       = NUM_SPI + LINES_PER_CPU * NUM_SLOTS;
  localparam int WORDS   = W / REG_BITS;
  localparam int AW      = $clog2(WORDS);
  localparam int IDW     = $clog2(NUM_IRQ);

  logic [W-1:0] chg;

  irq_state_bank #(
    .NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU), .W(W), .WORDS(WORDS), .AW(AW)
  ) u_bank (
    .clk(clk), .rst(rst), .lines_i(irq_lines_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .trig_we_i(cfg_trig_we_i), .clr_we_i(cfg_clr_we_i),
    .rd_trig_o(rd_trig_o), .rd_pend_o(rd_pend_o), .chg_o(chg), .err_o(map_err_o)
  );

  irq_upd_queue #(
    .NUM_SPI(NUM_SPI), .W(W), .IDW(IDW)
  ) u_queue (
    .clk(clk), .rst(rst), .chg_i(chg), .upd_valid_o(upd_valid_o),
    .upd_private_o(upd_private_o), .upd_num_o(upd_num_o)
  );

  // R2: a processor strobe names an existing processor
  assert_cpu_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_valid_o && upd_private_o) |-> (int'(upd_num_o) < NUM_CPU));

  // R1: a shared strobe names an ID above the private range
  assert_shared_id_range_R1: assert property (@(posedge clk) disable iff (rst)
    (upd_valid_o && !upd_private_o) |-> (int'(upd_num_o) >= LINES_PER_CPU));
endmodule

// File: tb/tb_irq_route_latch.sv
module tb_irq_route_latch;
  localparam int W = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [W-1:0] lines = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        trig_we = 1'b0, clr_we = 1'b0;
  logic [31:0] rd_trig, rd_pend;
  logic        upd_valid, upd_private, map_err;
  logic [5:0]  upd_num;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_route_latch dut (
    .clk(clk), .rst(rst), .irq_lines_i(lines), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_trig_we_i(trig_we), .cfg_clr_we_i(clr_we),
    .rd_trig_o(rd_trig), .rd_pend_o(rd_pend), .upd_valid_o(upd_valid),
    .upd_private_o(upd_private), .upd_num_o(upd_num), .map_err_o(map_err)
  );

  typedef struct packed {
    logic [7:0] line;
    logic       lvl;
    logic       ev;
    logic       epriv;
    logic [5:0] eid;
    logic       eerr;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{8'd3,   1'b1, 1'b1, 1'b0, 6'd35, 1'b0},
    '{8'd3,   1'b1, 1'b0, 1'b0, 6'd0,  1'b0},
    '{8'd3,   1'b0, 1'b1, 1'b0, 6'd35, 1'b0},
    '{8'd40,  1'b1, 1'b0, 1'b0, 6'd0,  1'b1},
    '{8'd40,  1'b0, 1'b0, 1'b0, 6'd0,  1'b0},
    '{8'd52,  1'b1, 1'b1, 1'b1, 6'd0,  1'b0},
    '{8'd84,  1'b1, 1'b1, 1'b1, 6'd1,  1'b0},
    '{8'd116, 1'b1, 1'b0, 1'b0, 6'd0,  1'b1},
    '{8'd116, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0},
    '{8'd31,  1'b1, 1'b1, 1'b0, 6'd63, 1'b0},
    '{8'd52,  1'b0, 1'b1, 1'b1, 6'd0,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_upd(input string req, input logic ev, input logic ep, input logic [5:0] eid);
    check(req, {31'd0, upd_valid}, {31'd0, ev});
    if (ev) check(req, {25'd0, upd_private, upd_num}, {25'd0, ep, eid});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic tw, input logic cw);
    @(negedge clk);
    addr = a; wdata = d; trig_we = tw; clr_we = cw;
    @(negedge clk);
    trig_we = 1'b0; clr_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    rd(2'd0);
    check("R10 strobe", {31'd0, upd_valid}, 32'd0);
    check("R10 err", {31'd0, map_err}, 32'd0);
    check("R10 pend", rd_pend, 32'd0);
    check("R10 trig", rd_trig, 32'd0);

    // R8: trigger configuration, reserved bits masked
    wr(2'd0, 32'h0000_00FF, 1'b1, 1'b0);
    wr(2'd1, 32'hFFFF_FFFF, 1'b1, 1'b0);
    wr(2'd2, 32'h0000_0000, 1'b1, 1'b0);
    wr(2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0);
    rd(2'd0); check("R8 word0", rd_trig, 32'h0000_00FF);
    rd(2'd1); check("R8 word1 reserved low half", rd_trig, 32'hFFFF_0000);
    rd(2'd3); check("R8 unused slot", rd_trig, 32'h0);

    // Table walk: R1 R2 R3 R5 R6
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      lines[TBL[i].line] = TBL[i].lvl;
      @(negedge clk);
      check_upd($sformatf("R1/R2/R3 row %0d", i), TBL[i].ev, TBL[i].epriv, TBL[i].eid);
      check($sformatf("R5/R6 err row %0d", i), {31'd0, map_err}, {31'd0, TBL[i].eerr});
    end

    // R4: edge pending, level lines never pend, falling does not clear
    rd(2'd0); check("R4 shared pend", rd_pend, 32'h0000_0008);
    rd(2'd1); check("R4 cpu0 pend", rd_pend, 32'h0010_0000);
    rd(2'd2); check("R4 level cpu1 no pend", rd_pend, 32'h0);
    rd(2'd3); check("R6 unused slot no pend", rd_pend, 32'h0);

    // R7: three lines at once, ascending order
    @(negedge clk);
    lines[60] = 1'b1; lines[5] = 1'b1; lines[1] = 1'b1;
    @(negedge clk); check_upd("R7 first", 1'b1, 1'b0, 6'd33);
    @(negedge clk); check_upd("R7 second", 1'b1, 1'b0, 6'd37);
    @(negedge clk); check_upd("R7 third", 1'b1, 1'b1, 6'd0);
    @(negedge clk); check_upd("R7 drained", 1'b0, 1'b0, 6'd0);

    // R9: clear and edge on the same bit, set wins
    @(negedge clk);
    addr = 2'd0; wdata = 32'h0000_0004; clr_we = 1'b1; lines[2] = 1'b1;
    @(negedge clk);
    clr_we = 1'b0;
    rd(2'd0); check("R9 set wins", rd_pend, 32'h0000_002E);
    rd(2'd1); check("R4 cpu0 after burst", rd_pend, 32'h1010_0000);
    wr(2'd0, 32'h0000_000A, 1'b0, 1'b1);
    rd(2'd0); check("R9 w1c", rd_pend, 32'h0000_0024);

    // R10: reset clears everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    lines = '0;
    rd(2'd0);
    check("R10 pend after reset", rd_pend, 32'h0);
    check("R10 trig after reset", rd_trig, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule